// File: doc/BRIEF.md
# Dual-Channel Thermal Duty Target Calculator

This block turns measured temperatures into a target fan duty cycle expressed in 1/255 steps (0 means stopped, 255 means full speed). A remote temperature and a local temperature arrive together with a one-cycle valid strobe. Each channel has its own control curve with three programmable parts:

- a low-temperature knee, below which the duty sits at a programmed minimum;
- a power-of-two slope, which sets the rise in duty per degree above the knee;
- a saturation point at full scale, which acts as the high-temperature limit.

A passive-cooling temperature stops the fan outright. A 2-bit mode input sets the control source. In one mode the remote channel alone sets the target. In the other mode both curves are evaluated and the faster one wins.

A final stage can force very small targets to zero. It does so only when the tachometer is enabled in its default mode, so that the fan is not run at a speed too low to measure. The result appears on a registered output one cycle after the input strobe, together with its own valid strobe. The PWM generator that consumes the target is outside this block.

Top module: `thermDutyTarget`

## Requirements
- R1: After reset `dutyOut` is 0 and `dutyValid` is 0. Each cycle with `tempValid` high gives `dutyValid` high in the next cycle, carrying the new target. `dutyValid` is low otherwise, and `dutyOut` holds its value between strobes.
- R2: When `modeSel` is not 2'b11 (2'b10 is the normal remote-only code), only the remote channel decides the target, and the local temperature and local parameters have no effect.
- R3: When `modeSel` is 2'b11, each channel computes its own target and the larger of the two becomes the output.
- R4: A channel's knee temperature is its 5-bit low field multiplied by 4 °C. At or below the knee, and above the passive temperature, the channel target equals `minDuty`.
- R5: Above the knee, the channel target is `minDuty + (T - knee) * 2^slope`, where the 3-bit slope code 0..7 gives 1..128 counts per °C.
- R6: Any channel result above 255 saturates to 255 (full speed). The high temperature is the point where the ramp reaches 255.
- R7: When a channel's temperature is at or below `passiveTemp`, that channel's target is 0. This rule takes precedence over the knee clamp.
- R8: When `tachEn` is 1 and `tachMode` is 0, a selected target below 18 counts (about 7%) is forced to 0. A target of exactly 18 passes unchanged.
- R9: When `tachEn` is 0 or `tachMode` is 1, small targets pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tempValid | input | 1 | Strobe: temperatures and settings are valid this cycle |
| remoteTemp | input | 8 | Remote temperature, °C unsigned |
| localTemp | input | 8 | Local temperature, °C unsigned |
| modeSel | input | 2 | 2'b11 selects the larger of both channels; any other code selects remote only |
| remLowField | input | 5 | Remote knee, in 4 °C units |
| remSlope | input | 3 | Remote slope code, 2^code counts per °C |
| locLowField | input | 5 | Local knee, in 4 °C units |
| locSlope | input | 3 | Local slope code |
| passiveTemp | input | 8 | Fan-off temperature, °C |
| minDuty | input | 8 | Duty at or below the knee |
| tachEn | input | 1 | Tachometer monitoring enabled |
| tachMode | input | 1 | Tachometer mode flag; 0 enables suppression of small targets |
| dutyOut | output | 8 | Registered target duty |
| dutyValid | output | 1 | One-cycle strobe that marks a new `dutyOut` |

## Verification
In the dual-channel mode, the maximum selection and the low-duty suppression act in the same evaluation. The case of interest is when both channel targets sit near the 18-count limit. The bench provokes this by programming a small `minDuty` with both temperatures under their knees, then moving one channel to exactly 18. When both targets are below 18, the expected output is 0. When the larger target is exactly 18, it must win and survive suppression. The passive-off rule is also combined with the maximum: one channel is stopped while the other ramps, and the ramping channel must still drive the output.

// File: rtl/thermDutyPkg.sv
package thermDutyPkg;
  localparam logic [1:0] MODE_MAX_OF_BOTH = 2'b11;

  typedef struct packed {
    logic capture;   // latch the datapath result this cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/thermChannel.sv
module thermChannel #(
  parameter int TEMP_W    = 8,
  parameter int LOW_W     = 5,
  parameter int SLOPE_W   = 3,
  parameter int DUTY_W    = 8,
  parameter int LOW_SHIFT = 2
) (
  input  logic [TEMP_W-1:0]  temp,
  input  logic [LOW_W-1:0]   lowField,
  input  logic [SLOPE_W-1:0] slope,
  input  logic [TEMP_W-1:0]  passiveTemp,
  input  logic [DUTY_W-1:0]  minDuty,
  output logic [DUTY_W-1:0]  duty
);
  localparam int RAMP_W = TEMP_W + (1 << SLOPE_W);
  localparam logic [RAMP_W-1:0] DUTY_FULL = RAMP_W'((1 << DUTY_W) - 1);

  logic [TEMP_W-1:0] kneeTemp;
  logic [TEMP_W-1:0] overKnee;
  logic [RAMP_W-1:0] rampAdd;
  logic [RAMP_W-1:0] rampTotal;

  assign kneeTemp  = TEMP_W'(lowField) << LOW_SHIFT;
  assign overKnee  = temp - kneeTemp;
  assign rampAdd   = RAMP_W'(overKnee) << slope;
  assign rampTotal = rampAdd + RAMP_W'(minDuty);

  // Precedence: passive stop, knee clamp, saturating ramp.
  always_comb begin
    if (temp <= passiveTemp)
      duty = '0;
    else if (temp <= kneeTemp)
      duty = minDuty;
    else if (rampTotal > DUTY_FULL)
      duty = DUTY_W'(DUTY_FULL);
    else
      duty = rampTotal[DUTY_W-1:0];
  end
endmodule

// File: rtl/thermDutyDatapath.sv
module thermDutyDatapath
  import thermDutyPkg::*;
#(
  parameter int TEMP_W       = 8,
  parameter int LOW_W        = 5,
  parameter int SLOPE_W      = 3,
  parameter int DUTY_W       = 8,
  parameter int LOW_SHIFT    = 2,
  parameter int SUPPRESS_LIM = 18
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       ctrl,
  input  logic [TEMP_W-1:0]  remoteTemp,
  input  logic [TEMP_W-1:0]  localTemp,
  input  logic [1:0]         modeSel,
  input  logic [LOW_W-1:0]   remLowField,
  input  logic [SLOPE_W-1:0] remSlope,
  input  logic [LOW_W-1:0]   locLowField,
  input  logic [SLOPE_W-1:0] locSlope,
  input  logic [TEMP_W-1:0]  passiveTemp,
  input  logic [DUTY_W-1:0]  minDuty,
  input  logic               tachEn,
  input  logic               tachMode,
  output logic [DUTY_W-1:0]  dutyOut
);
  localparam int NUM_CH = 2;   // index 0 remote, 1 local
  localparam logic [DUTY_W-1:0] LIM = DUTY_W'(SUPPRESS_LIM);

  logic [NUM_CH-1:0][TEMP_W-1:0]  chTemp;
  logic [NUM_CH-1:0][LOW_W-1:0]   chLow;
  logic [NUM_CH-1:0][SLOPE_W-1:0] chSlope;
  logic [NUM_CH-1:0][DUTY_W-1:0]  chDuty;
  logic [DUTY_W-1:0] pickedDuty;
  logic [DUTY_W-1:0] finalDuty;
  logic suppressOn;

  assign chTemp  = {localTemp, remoteTemp};
  assign chLow   = {locLowField, remLowField};
  assign chSlope = {locSlope, remSlope};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    thermChannel #(
      .TEMP_W(TEMP_W), .LOW_W(LOW_W), .SLOPE_W(SLOPE_W),
      .DUTY_W(DUTY_W), .LOW_SHIFT(LOW_SHIFT)
    ) u_chan (
      .temp(chTemp[c]), .lowField(chLow[c]), .slope(chSlope[c]),
      .passiveTemp(passiveTemp), .minDuty(minDuty), .duty(chDuty[c])
    );
  end

  always_comb begin
    pickedDuty = chDuty[0];
    if (modeSel == MODE_MAX_OF_BOTH && chDuty[1] > chDuty[0])
      pickedDuty = chDuty[1];
  end

  assign suppressOn = tachEn && !tachMode;
  assign finalDuty  = (suppressOn && pickedDuty < LIM) ? '0 : pickedDuty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      dutyOut <= '0;
    else if (ctrl.capture)
      dutyOut <= finalDuty;
  end
endmodule

// File: rtl/thermDutyControl.sv
module thermDutyControl
  import thermDutyPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tempValid,
  output ctrlStrobes_t ctrl,
  output logic         dutyValid
);
  always_comb ctrl.capture = tempValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      dutyValid <= 1'b0;
    else
      dutyValid <= tempValid;
  end
endmodule

// File: rtl/thermDutyTarget.sv
module thermDutyTarget
  import thermDutyPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tempValid,
  input  logic [7:0] remoteTemp,
  input  logic [7:0] localTemp,
  input  logic [1:0] modeSel,
  input  logic [4:0] remLowField,
  input  logic [2:0] remSlope,
  input  logic [4:0] locLowField,
  input  logic [2:0] locSlope,
  input  logic [7:0] passiveTemp,
  input  logic [7:0] minDuty,
  input  logic       tachEn,
  input  logic       tachMode,
  output logic [7:0] dutyOut,
  output logic       dutyValid
);
  ctrlStrobes_t ctrl;

  thermDutyControl u_ctrl (
    .clk(clk), .rstN(rstN), .tempValid(tempValid),
    .ctrl(ctrl), .dutyValid(dutyValid)
  );

  thermDutyDatapath #(
    .TEMP_W(8), .LOW_W(5), .SLOPE_W(3), .DUTY_W(8),
    .LOW_SHIFT(2), .SUPPRESS_LIM(18)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .remoteTemp(remoteTemp), .localTemp(localTemp), .modeSel(modeSel),
    .remLowField(remLowField), .remSlope(remSlope),
    .locLowField(locLowField), .locSlope(locSlope),
    .passiveTemp(passiveTemp), .minDuty(minDuty),
    .tachEn(tachEn), .tachMode(tachMode), .dutyOut(dutyOut)
  );
endmodule

// File: rtl/thermDutyTargetChk.sv
module thermDutyTargetChk (
  input logic       clk,
  input logic       rstN,
  input logic       tempValid,
  input logic [7:0] remoteTemp,
  input logic [7:0] localTemp,
  input logic [1:0] modeSel,
  input logic [4:0] remLowField,
  input logic [2:0] remSlope,
  input logic [4:0] locLowField,
  input logic [2:0] locSlope,
  input logic [7:0] passiveTemp,
  input logic [7:0] minDuty,
  input logic       tachEn,
  input logic       tachMode,
  input logic [7:0] dutyOut,
  input logic       dutyValid
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    tempValid |=> dutyValid);

  assert_valid_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !tempValid |=> !dutyValid);

  assert_duty_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    !tempValid |=> $stable(dutyOut));

  assert_passive_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tempValid && modeSel != 2'b11 && remoteTemp <= passiveTemp) |=> dutyOut == 8'd0);

  assert_knee_min_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tempValid && modeSel != 2'b11 && remoteTemp > passiveTemp &&
     remoteTemp <= {1'b0, remLowField, 2'b00} && !tachEn) |=> dutyOut == $past(minDuty));

  assert_no_small_duty_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tempValid && tachEn && !tachMode) |=> (dutyOut == 8'd0 || dutyOut >= 8'd18));

  assert_max_not_below_remote_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tempValid && modeSel == 2'b11 && remoteTemp > passiveTemp && !tachEn &&
     remoteTemp <= {1'b0, remLowField, 2'b00}) |=> dutyOut >= $past(minDuty));

  logic unusedSum;
  assign unusedSum = ^{localTemp, remSlope, locLowField, locSlope};
endmodule

bind thermDutyTarget thermDutyTargetChk u_chk (.*);

// File: tb/thermDutyTarget_tb.sv
module thermDutyTarget_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tempValid = 1'b0;
  logic [7:0] remoteTemp = '0, localTemp = '0;
  logic [1:0] modeSel = 2'b10;
  logic [4:0] remLowField = '0, locLowField = '0;
  logic [2:0] remSlope = '0, locSlope = '0;
  logic [7:0] passiveTemp = '0, minDuty = '0;
  logic       tachEn = 1'b0, tachMode = 1'b0;
  logic [7:0] dutyOut;
  logic       dutyValid;

  int checks = 0;
  int failures = 0;
  int expQ[$];
  string tagQ[$];
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  thermDutyTarget u_dut (.*);

  function automatic int chanModel(int t, int lowF, int slope, int passive, int minD);
    int knee, v;
    knee = lowF * 4;
    if (t <= passive) return 0;
    if (t <= knee) return minD;
    v = minD + (t - knee) * (1 << slope);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic int fullModel();
    int r, l, p;
    r = chanModel(remoteTemp, remLowField, remSlope, passiveTemp, minDuty);
    l = chanModel(localTemp, locLowField, locSlope, passiveTemp, minDuty);
    p = (modeSel == 2'b11 && l > r) ? l : r;
    if (tachEn && !tachMode && p < 18) p = 0;
    return p;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: apply a stimulus for one strobe and queue its expected value.
  task automatic drive(string tag, int exp, logic [7:0] rT, logic [7:0] lT);
    @(negedge clk);
    remoteTemp = rT;
    localTemp  = lT;
    tempValid  = 1'b1;
    check({tag, " model"}, fullModel(), exp);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    tempValid = 1'b0;
  endtask

  task automatic setParams(logic [1:0] m, logic [4:0] rl, logic [2:0] rs,
                           logic [4:0] ll, logic [2:0] ls, logic [7:0] pv,
                           logic [7:0] md, logic te, logic tm);
    modeSel = m; remLowField = rl; remSlope = rs; locLowField = ll;
    locSlope = ls; passiveTemp = pv; minDuty = md; tachEn = te; tachMode = tm;
  endtask

  // Monitor: pop and compare every published result.
  always @(negedge clk) begin
    if (rstN && dutyValid) begin
      if (expQ.size() == 0) begin
        check("R1 unexpected valid", 1, 0);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, dutyOut, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset dutyOut", dutyOut, 0);
    check("R1 reset dutyValid", dutyValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Remote-only mode, knee 40 C, passive 20 C, minimum duty 50
    setParams(2'b10, 5'd10, 3'd0, 5'd2, 3'd7, 8'd20, 8'd50, 1'b0, 1'b0);
    drive("R4 knee clamp", 50, 8'd30, 8'd0);
    drive("R4 exactly at knee", 50, 8'd40, 8'd0);
    remSlope = 3'd2;
    drive("R5 ramp x4", 70, 8'd45, 8'd0);
    remSlope = 3'd0;
    drive("R6 just below full", 254, 8'd244, 8'd0);
    drive("R6 reaches full", 255, 8'd245, 8'd0);
    remSlope = 3'd3;
    drive("R6 saturates", 255, 8'd100, 8'd0);
    drive("R7 passive stop", 0, 8'd20, 8'd0);
    drive("R7 above passive", 50, 8'd21, 8'd0);
    passiveTemp = 8'd60;
    drive("R7 passive over knee", 0, 8'd55, 8'd0);
    passiveTemp = 8'd20;

    // Local channel is hot and steep but must be ignored
    drive("R2 local ignored", 50, 8'd30, 8'd200);
    modeSel = 2'b01;
    drive("R2 other code remote only", 50, 8'd30, 8'd200);

    // R1: hold between strobes
    repeat (2) @(negedge clk);
    remoteTemp = 8'd200;
    repeat (3) @(negedge clk);
    check("R1 hold without strobe", dutyOut, 50);
    check("R1 no valid without strobe", dutyValid, 0);

    // Max-of-both mode
    setParams(2'b11, 5'd10, 3'd2, 5'd10, 3'd1, 8'd20, 8'd50, 1'b0, 1'b0);
    drive("R3 local wins", 90, 8'd45, 8'd60);
    drive("R3 remote wins", 170, 8'd70, 8'd41);
    drive("R3 with R7 remote stopped", 90, 8'd15, 8'd60);
    drive("R3 with R7 local stopped", 70, 8'd45, 8'd10);

    // Suppression of small targets
    setParams(2'b10, 5'd10, 3'd0, 5'd10, 3'd0, 8'd20, 8'd10, 1'b1, 1'b0);
    drive("R8 small forced zero", 0, 8'd30, 8'd0);
    minDuty = 8'd17;
    drive("R8 17 forced zero", 0, 8'd30, 8'd0);
    minDuty = 8'd18;
    drive("R8 18 passes", 18, 8'd30, 8'd0);
    setParams(2'b10, 5'd10, 3'd0, 5'd10, 3'd0, 8'd20, 8'd10, 1'b1, 1'b1);
    drive("R9 tach mode set", 10, 8'd30, 8'd0);
    tachEn = 1'b0; tachMode = 1'b0;
    drive("R9 tach disabled", 10, 8'd30, 8'd0);

    // Coincidence: maximum selection and suppression
    setParams(2'b11, 5'd10, 3'd0, 5'd10, 3'd0, 8'd20, 8'd10, 1'b1, 1'b0);
    drive("R3 R8 both small", 0, 8'd30, 8'd35);
    drive("R3 R8 larger is 18", 18, 8'd30, 8'd48);
    drive("R3 R8 remote 18", 18, 8'd48, 8'd30);

    repeat (4) @(negedge clk);
    check("R1 queue drained", expQ.size(), 0);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule